// File: doc/BRIEF.md
# Beacon-Synchronized Radio Sleep Controller

This block decides when a wireless receiver has power. By default the radio sleeps. It wakes on a fixed schedule so that each periodic beacon from the access point arrives while the receiver is on. A beacon carries a list of stations that have frames waiting. A frame parser upstream presents that list one station ID per valid cycle, with a flag on the final entry. If the station's own ID is in the list, the radio stays on to take the pending frame. Otherwise it goes back to sleep as soon as the list ends.

The first beacon entry that is heard sets the schedule. A period counter then runs freely, whatever the radio is doing. A programmable guard wakes the receiver a few cycles ahead of the expected beacon. A listen timeout returns it to sleep when a beacon never shows up, and a saturating counter records each such miss. A transmit request wakes the radio at once, with no wait for a beacon. After reset the radio stays on until it hears its first beacon.

Top module: `beacon_sleep_ctrl`

## Requirements
- R1: In the cycle after reset the state is BOOT (code 0), `radio_on` is 1 and `miss_cnt` is 0. The block stays in BOOT with the radio on until a beacon entry arrives.
- R2: Beacon entries are accepted only in BOOT, LISTEN (2) and SCAN (3). An entry presented in DOZE (1) or XMIT (5) changes neither the state nor the wake schedule.
- R3: The clock edge that accepts the first entry of a list (edge B) restarts the period counter. The next beacon is expected at edge B+P, where P = `cfg_period`. The counter keeps running through every state, so the expected beacon times stay B+kP until a new beacon is heard.
- R4: With guard G (1 ≤ G < P), the edge at B+P−G moves DOZE to LISTEN and turns the radio on. The radio is still off after edge B+P−G−1.
- R5: With listen timeout T ≥ 1, an entry is accepted at any edge up to B+P+T. If none arrives, edge B+P+T returns the block to DOZE with the radio off and adds one to `miss_cnt`.
- R6: `miss_cnt` saturates at 2^MISS_W−1.
- R7: List entries may have idle cycles between them. The state is SCAN between the first and the last entry. If `self_id` matched any entry, the edge that accepts the last entry moves to RECV (4). Otherwise it moves to DOZE.
- R8: RECV lasts until `rx_done` is sampled high, or for at most R = `cfg_rx_wait` cycles, and then returns to DOZE.
- R9: A `tx_req` sampled high in DOZE moves to XMIT with the radio on at that edge. XMIT holds while `tx_req` stays high, and the block returns to DOZE at the first edge that samples it low.
- R10: A list of a single entry, first and last at once, is handled at one edge: it resynchronizes the period counter and goes straight to RECV or DOZE.
- R11: If an entry arrives at the same edge as the listen timeout, the entry wins. No miss is counted and the list is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | CNT_W | Beacon interval in cycles |
| cfg_guard | input | CNT_W | Cycles of early wake before the expected beacon |
| cfg_bcn_wait | input | CNT_W | Cycles to keep listening after the expected beacon |
| cfg_rx_wait | input | CNT_W | Maximum cycles to stay awake for a pending frame |
| self_id | input | ID_W | This station's ID |
| bcn_valid | input | 1 | A beacon recipient entry is present |
| bcn_id | input | ID_W | Recipient ID of the entry |
| bcn_last | input | 1 | Entry is the final one of the list |
| tx_req | input | 1 | Outgoing traffic needs the radio |
| rx_done | input | 1 | The pending frame has been received |
| radio_on | output | 1 | Receiver power enable, registered |
| pwr_state | output | 3 | State code: 0 BOOT, 1 DOZE, 2 LISTEN, 3 SCAN, 4 RECV, 5 XMIT |
| miss_cnt | output | MISS_W | Saturating count of missed beacons |

## Verification
The bench sweeps every pairing of guard and listen timeout from 1 to 3 and measures wake and sleep edges against beacon edges it records. This exposes off-by-one errors in the guard, a window that closes one edge early or late, and a timer that loses alignment after a miss or after a transmit burst.

It sends an entry on the very edge the window closes. A design that gives the timeout priority would count a miss and drop a frame. It places the station's ID in the middle of a list that has gaps. A design that keeps only the last comparison would sleep through its own traffic.

It also sends beacons while the block sleeps and while it transmits. A design that accepts them would shift its schedule or start a spurious reception. Finally, it runs out enough misses to overflow a 2-bit counter, to check that the count sticks at its maximum.

// File: rtl/bcn_pkg.sv
package bcn_pkg;
  typedef enum logic [2:0] {
    ST_BOOT   = 3'd0,
    ST_DOZE   = 3'd1,
    ST_LISTEN = 3'd2,
    ST_SCAN   = 3'd3,
    ST_RECV   = 3'd4,
    ST_XMIT   = 3'd5
  } pwr_state_e;
endpackage

// File: rtl/bcn_period_timer.sv
module bcn_period_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] guard,
  input  logic             resync,
  output logic             wake_pt
);
  logic [CNT_W-1:0] to_next;
  logic [CNT_W-1:0] reload;

  assign reload  = period - CNT_W'(1);
  assign wake_pt = (to_next == guard);

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      to_next <= reload;
    end else if (to_next == '0) begin
      to_next <= reload;
    end else begin
      to_next <= to_next - CNT_W'(1);
    end
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    (period != '0) |-> (to_next < period)); // R3
  AST_TIMER_RESYNC: assert property (@(posedge clk) disable iff (rst)
    (resync && $stable(period)) |=> (to_next == reload)); // R3
endmodule

// File: rtl/bcn_list_scan.sv
module bcn_list_scan #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [ID_W-1:0] item_id,
  input  logic            item_last,
  input  logic [ID_W-1:0] own_id,
  output logic            list_start,
  output logic            list_done,
  output logic            list_hit
);
  logic in_list;
  logic hit_q;
  logic match;

  assign match      = (item_id == own_id);
  assign list_start = accept && !in_list;
  assign list_done  = accept && item_last;
  assign list_hit   = hit_q || match;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_list <= 1'b0;
      hit_q   <= 1'b0;
    end else if (accept) begin
      if (item_last) begin
        in_list <= 1'b0;
        hit_q   <= 1'b0;
      end else begin
        in_list <= 1'b1;
        hit_q   <= hit_q || match;
      end
    end
  end

  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (hit_q && !list_done) |=> hit_q); // R7
  AST_START_ONCE: assert property (@(posedge clk) disable iff (rst)
    (list_start && !item_last) |=> !list_start); // R7
endmodule

// File: rtl/bcn_pwr_fsm.sv
module bcn_pwr_fsm
  import bcn_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  guard,
  input  logic [CNT_W-1:0]  bcn_wait,
  input  logic [CNT_W-1:0]  rx_wait,
  input  logic              wake_pt,
  input  logic              list_start,
  input  logic              list_done,
  input  logic              list_hit,
  input  logic              tx_req,
  input  logic              rx_done,
  output logic              listening,
  output logic              radio_on,
  output logic [2:0]        state_code,
  output logic [MISS_W-1:0] miss_cnt
);
  localparam int DW = CNT_W + 1;

  pwr_state_e      state, nxt;
  logic [DW-1:0]   dwell;
  logic [DW-1:0]   listen_lim;
  logic [DW-1:0]   rx_lim;
  logic            miss_inc;
  logic            after_list;

  assign listen_lim = DW'(guard) + DW'(bcn_wait) - DW'(1);
  assign rx_lim     = DW'(rx_wait) - DW'(1);
  assign listening  = (state == ST_BOOT) || (state == ST_LISTEN) || (state == ST_SCAN);
  assign state_code = state;
  assign after_list = list_hit ? 1'b1 : 1'b0;

  always_comb begin
    nxt      = state;
    miss_inc = 1'b0;
    case (state)
      ST_BOOT: begin
        if (list_done)       nxt = after_list ? ST_RECV : ST_DOZE;
        else if (list_start) nxt = ST_SCAN;
      end
      ST_LISTEN: begin
        if (list_done)       nxt = after_list ? ST_RECV : ST_DOZE;
        else if (list_start) nxt = ST_SCAN;
        else if (dwell == listen_lim) begin
          nxt      = ST_DOZE;
          miss_inc = 1'b1;
        end
      end
      ST_SCAN: begin
        if (list_done) nxt = after_list ? ST_RECV : ST_DOZE;
      end
      ST_RECV: begin
        if (rx_done || dwell == rx_lim) nxt = ST_DOZE;
      end
      ST_DOZE: begin
        if (tx_req)       nxt = ST_XMIT;
        else if (wake_pt) nxt = ST_LISTEN;
      end
      ST_XMIT: begin
        if (!tx_req) nxt = ST_DOZE;
      end
      default: nxt = ST_DOZE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_BOOT;
      radio_on <= 1'b1;
      dwell    <= '0;
      miss_cnt <= '0;
    end else begin
      state    <= nxt;
      radio_on <= (nxt != ST_DOZE);
      dwell    <= (nxt != state) ? '0 : dwell + DW'(1);
      if (miss_inc && miss_cnt != '1) miss_cnt <= miss_cnt + MISS_W'(1);
    end
  end

  AST_TX_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOZE && tx_req) |=> (radio_on && state == ST_XMIT)); // R9
  AST_DOZE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOZE && !tx_req && !wake_pt) |=> (state == ST_DOZE && !radio_on)); // R2
  AST_LISTEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LISTEN) |-> (dwell <= listen_lim)); // R5
  AST_RECV_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV && rx_wait != '0) |-> (dwell <= rx_lim)); // R8
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LISTEN && !list_start && dwell == listen_lim && miss_cnt != '1)
    |=> (miss_cnt == MISS_W'($past(miss_cnt) + 1'b1))); // R5
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt == '1) |=> (miss_cnt == '1)); // R6
  AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BOOT && !list_start && !list_done) |=> (state == ST_BOOT && radio_on)); // R1
endmodule

// File: rtl/beacon_sleep_ctrl.sv
module beacon_sleep_ctrl #(
  parameter int CNT_W  = 16,
  parameter int ID_W   = 8,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic [CNT_W-1:0]  cfg_guard,
  input  logic [CNT_W-1:0]  cfg_bcn_wait,
  input  logic [CNT_W-1:0]  cfg_rx_wait,
  input  logic [ID_W-1:0]   self_id,
  input  logic              bcn_valid,
  input  logic [ID_W-1:0]   bcn_id,
  input  logic              bcn_last,
  input  logic              tx_req,
  input  logic              rx_done,
  output logic              radio_on,
  output logic [2:0]        pwr_state,
  output logic [MISS_W-1:0] miss_cnt
);
  logic listening;
  logic accept;
  logic list_start;
  logic list_done;
  logic list_hit;
  logic wake_pt;

  assign accept = bcn_valid && listening;

  bcn_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .period  (cfg_period),
    .guard   (cfg_guard),
    .resync  (list_start),
    .wake_pt (wake_pt)
  );

  bcn_list_scan #(.ID_W(ID_W)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .item_id    (bcn_id),
    .item_last  (bcn_last),
    .own_id     (self_id),
    .list_start (list_start),
    .list_done  (list_done),
    .list_hit   (list_hit)
  );

  bcn_pwr_fsm #(.CNT_W(CNT_W), .MISS_W(MISS_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .guard      (cfg_guard),
    .bcn_wait   (cfg_bcn_wait),
    .rx_wait    (cfg_rx_wait),
    .wake_pt    (wake_pt),
    .list_start (list_start),
    .list_done  (list_done),
    .list_hit   (list_hit),
    .tx_req     (tx_req),
    .rx_done    (rx_done),
    .listening  (listening),
    .radio_on   (radio_on),
    .state_code (pwr_state),
    .miss_cnt   (miss_cnt)
  );
endmodule

// File: tb/beacon_sleep_ctrl_test.sv
`timescale 1ns/1ps
module beacon_sleep_ctrl_test;
  localparam int CNT_W = 6;
  localparam int ID_W = 4;
  localparam int MISS_W = 2;
  localparam int P = 16;
  localparam int RT = 4;
  localparam int ME = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] cfg_guard = '0;
  logic [CNT_W-1:0] cfg_bcn_wait = '0;
  logic bcn_valid = 1'b0;
  logic [ID_W-1:0] bcn_id = '0;
  logic bcn_last = 1'b0;
  logic tx_req = 1'b0;
  logic rx_done = 1'b0;
  logic radio_on;
  logic [2:0] pwr_state;
  logic [MISS_W-1:0] miss_cnt;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  beacon_sleep_ctrl #(.CNT_W(CNT_W), .ID_W(ID_W), .MISS_W(MISS_W)) uut (
    .clk(clk), .rst(rst),
    .cfg_period(CNT_W'(P)), .cfg_guard(cfg_guard),
    .cfg_bcn_wait(cfg_bcn_wait), .cfg_rx_wait(CNT_W'(RT)),
    .self_id(ID_W'(ME)),
    .bcn_valid(bcn_valid), .bcn_id(bcn_id), .bcn_last(bcn_last),
    .tx_req(tx_req), .rx_done(rx_done),
    .radio_on(radio_on), .pwr_state(pwr_state), .miss_cnt(miss_cnt)
  );

  task automatic tick();
    @(posedge clk);
    cyc = cyc + 1;
    @(negedge clk);
  endtask

  task automatic run_to(input int n);
    while (cyc < n) tick();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic item(input int id, input bit last);
    bcn_valid = 1'b1;
    bcn_id = ID_W'(id);
    bcn_last = last;
    tick();
    bcn_valid = 1'b0;
    bcn_last = 1'b0;
  endtask

  task automatic run_cfg(input int g, input int t);
    int b, x, x2;
    cfg_guard = CNT_W'(g);
    cfg_bcn_wait = CNT_W'(t);
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    chk("R1 state", pwr_state, 0);
    chk("R1 radio", radio_on, 1);
    chk("R1 miss", miss_cnt, 0);
    tick(); tick(); tick();
    chk("R1 stays awake", radio_on, 1);
    chk("R1 stays boot", pwr_state, 0);
    // first beacon: two foreign IDs with an idle gap
    item(1, 1'b0);
    b = cyc;
    chk("R7 scan", pwr_state, 3);
    tick();
    chk("R7 gap keeps scan", pwr_state, 3);
    item(2, 1'b1);
    chk("R7 not listed sleeps", pwr_state, 1);
    chk("R7 radio off", radio_on, 0);
    run_to(b + P - g - 1);
    chk("R4 still asleep", radio_on, 0);
    tick();
    chk("R4 wake", radio_on, 1);
    chk("R4 listen", pwr_state, 2);
    run_to(b + P + t - 1);
    chk("R5 window open", radio_on, 1);
    tick();
    chk("R5 timeout sleep", radio_on, 0);
    chk("R5 miss counted", miss_cnt, 1);
    run_to(b + 2*P - g - 1);
    chk("R3 free run asleep", radio_on, 0);
    tick();
    chk("R3 free run wake", radio_on, 1);
    // beacon on the last edge of the window, own ID mid-list
    run_to(b + 2*P + t - 1);
    item(3, 1'b0);
    x = cyc;
    chk("R11 late beacon accepted", pwr_state, 3);
    chk("R11 no miss", miss_cnt, 1);
    item(ME, 1'b0);
    item(4, 1'b1);
    chk("R7 own ID receive", pwr_state, 4);
    run_to(x + 1 + RT);
    chk("R8 receive held", radio_on, 1);
    tick();
    chk("R8 receive timeout", pwr_state, 1);
    run_to(x + P - g - 1);
    chk("R3 resync asleep", radio_on, 0);
    tick();
    chk("R3 resync wake", radio_on, 1);
    run_to(x + P - 1);
    item(ME, 1'b1);
    x2 = cyc;
    chk("R10 single entry receive", pwr_state, 4);
    tick();
    chk("R8 receive", pwr_state, 4);
    rx_done = 1'b1;
    tick();
    rx_done = 1'b0;
    chk("R8 rx_done sleep", pwr_state, 1);
    run_to(x2 + 3);
    item(ME, 1'b1);
    chk("R2 ignored in doze", pwr_state, 1);
    chk("R2 radio stays off", radio_on, 0);
    tx_req = 1'b1;
    tick();
    chk("R9 tx wake state", pwr_state, 5);
    chk("R9 tx wake radio", radio_on, 1);
    item(ME, 1'b1);
    chk("R2 ignored in xmit", pwr_state, 5);
    tick();
    chk("R9 tx held", pwr_state, 5);
    tx_req = 1'b0;
    tick();
    chk("R9 tx release", pwr_state, 1);
    chk("R9 radio off", radio_on, 0);
    run_to(x2 + P - g - 1);
    chk("R2 schedule kept asleep", radio_on, 0);
    tick();
    chk("R2 schedule kept wake", radio_on, 1);
    run_to(x2 + P + t);
    chk("R5 second miss", miss_cnt, 2);
    run_to(x2 + 2*P + t);
    chk("R6 third miss", miss_cnt, 3);
    run_to(x2 + 3*P + t);
    chk("R6 saturated", miss_cnt, 3);
    chk("R5 asleep after miss", radio_on, 0);
  endtask

  initial begin
    @(negedge clk);
    for (int g = 1; g <= 3; g++) begin
      for (int t = 1; t <= 3; t++) begin
        run_cfg(g, t);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog R1: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule